// File: doc/BRIEF.md
# Processor Bus Cycle Sequencer

This block produces the external bus timing of an 8-bit processor with a 16-bit address space. The core side hands it one machine-cycle request at a time: an opcode fetch, a memory read or write, or an I/O read or write, together with an address and write data. The block then steps through the T-states of that cycle, one clock per T-state. It drives the active-low memory request, I/O request, read, write, first-cycle and refresh strobes. It also drives the address and write data, and returns the byte read from the bus.

Slow devices stretch a cycle by pulling the wait input low. Every I/O cycle gets one wait state on its own, before the wait input is consulted. Each opcode fetch closes with two refresh T-states. In these, a 7-bit refresh counter appears on the low address lines and the counter then advances. An external master may ask for the bus. The block grants it only between machine cycles. While the bus is granted, the block turns off the output enables of the address bus, the data bus and the four bus strobes, and signals the grant.

The block will not start until reset has been held for a minimum number of consecutive clocks.

Top module: `bus_cycle_seq`

## Requirements
- R1: While `rst` is high, all three output enables are low, every active-low strobe and `busack_n` are high, and `req_ready` is low. The block starts working only on the first clock after a reset of at least RST_MIN (3) consecutive cycles. A shorter reset pulse leaves it idle, with `req_ready` and `addr_oe` low and no strobe asserted, until a full-length reset arrives.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both high. T1 of that cycle occupies the next clock. `done` is high for exactly the one clock after the last T-state, and at that point `rdata` holds the read byte. The `req_kind` codes are: 0 opcode fetch, 1 memory read, 2 memory write, 3 I/O read, 4 I/O write.
- R3: An opcode fetch takes T1, T2, the inserted waits, T3 and T4, which is 4 + W T-states for W waits. From T1 through the last wait state, `m1_n`, `mreq_n` and `rd_n` are low and `addr` carries the request address.
- R4: In T3 and T4 of a fetch, only `rfsh_n` and `mreq_n` are low. `addr[6:0]` shows the refresh counter and `addr[15:7]` is zero. The counter starts at 0 after reset, goes up by one (modulo 128) after every fetch, and never changes bit 7.
- R5: A memory read or write takes T1, T2, the waits and T3, which is 3 + W T-states. `mreq_n` is low throughout. `rd_n` is low throughout for a read. `wr_n` is low from T2 to the end for a write. For a write, `data_oe` is high and `dout` equals the write data from T1 to T3.
- R6: An I/O read or write takes T1, T2, one automatic wait, the requested waits and T3, which is 4 + W T-states. No strobe is asserted in T1. From T2 to the end, `iorq_n` is low together with `rd_n` (read) or `wr_n` (write). For a write, `data_oe` is high from T1 to T3.
- R7: `wait_n` is sampled at the end of T2 (memory and fetch), or at the end of the automatic wait (I/O), and at the end of every inserted wait. Each low sample adds one wait state. A low level during T1 has no effect.
- R8: A fetch latches `din` at the edge that ends its last RD-carrying T-state, before the refresh begins. A memory or I/O read latches at the edge that ends T3.
- R9: A low `busreq_n` is honoured only when idle or at the end of a machine cycle. On the next clock, `busack_n` goes low, `addr_oe`, `data_oe` and `ctrl_oe` go low, and no request is accepted. One clock after `busreq_n` returns high, `busack_n` is high again. A running cycle completes unchanged.
- R10: `mreq_n` and `iorq_n` are never low together, and `rd_n` and `wr_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period per T-state |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Cycle request present |
| req_kind | input | 3 | Cycle kind code |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | Request can be taken this clock |
| done | output | 1 | One-clock pulse after a cycle ends |
| rdata | output | 8 | Last byte read |
| wait_n | input | 1 | Active-low wait from slow devices |
| busreq_n | input | 1 | Active-low external bus request |
| busack_n | output | 1 | Active-low bus grant |
| addr | output | 16 | Address bus value |
| addr_oe | output | 1 | Address bus drive enable |
| din | input | 8 | Data bus value from devices |
| dout | output | 8 | Data bus value to devices |
| data_oe | output | 1 | Data bus drive enable |
| mreq_n | output | 1 | Memory request strobe |
| iorq_n | output | 1 | I/O request strobe |
| rd_n | output | 1 | Read strobe |
| wr_n | output | 1 | Write strobe |
| ctrl_oe | output | 1 | Drive enable of mreq_n, iorq_n, rd_n, wr_n |
| m1_n | output | 1 | First-cycle (opcode fetch) marker |
| rfsh_n | output | 1 | Refresh marker |

## Verification
The bench sweeps every cycle kind against zero to three requested waits. It compares each T-state's strobes with a table built from the requirements and checks the cycle length arithmetically. A sequencer that sampled wait in T1, or forgot the automatic I/O wait, would come out one T-state off. A fetch that latched data during refresh would return the idle filler byte instead of memory contents. A run of 130 fetches carries the refresh counter across its wrap, which would catch a counter that spilled into bit 7. Bus requests raised in the middle of a cycle show whether the grant waits for the boundary. A two-clock reset pulse shows whether the block starts up too early.

// File: rtl/busseq_pkg.sv
package busseq_pkg;

    typedef enum logic [2:0] {
        CK_FETCH = 3'd0,
        CK_MEMRD = 3'd1,
        CK_MEMWR = 3'd2,
        CK_IORD  = 3'd3,
        CK_IOWR  = 3'd4
    } cyc_kind_e;

    typedef enum logic [2:0] {
        TS_IDLE,
        TS_T1,
        TS_T2,
        TS_TAUTO,
        TS_TW,
        TS_T3,
        TS_T4,
        TS_HOLD
    } tstate_e;

    // Strobe set, active high inside the block.
    typedef struct packed {
        logic mreq;
        logic iorq;
        logic rd;
        logic wr;
        logic m1;
        logic rfsh;
    } strobes_t;

    function automatic logic kind_is_io(cyc_kind_e k);
        return (k == CK_IORD) || (k == CK_IOWR);
    endfunction

    function automatic logic kind_is_write(cyc_kind_e k);
        return (k == CK_MEMWR) || (k == CK_IOWR);
    endfunction

    function automatic logic kind_is_fetch(cyc_kind_e k);
        return k == CK_FETCH;
    endfunction

    function automatic logic in_refresh(tstate_e s, cyc_kind_e k);
        return kind_is_fetch(k) && ((s == TS_T3) || (s == TS_T4));
    endfunction

    // T-states during which a write cycle drives the data bus.
    function automatic logic data_phase(tstate_e s);
        return (s == TS_T1) || (s == TS_T2) || (s == TS_TAUTO) ||
               (s == TS_TW) || (s == TS_T3);
    endfunction

endpackage

// File: rtl/busseq_rstq.sv
// Reset qualifier: the block runs only after rst has been high for
// RST_MIN consecutive clocks and has then been released.
module busseq_rstq #(
    parameter int RST_MIN = 3
) (
    input  logic clk,
    input  logic rst,
    output logic live
);

    logic [RST_MIN-1:0] hist;
    logic               armed;

    always_ff @(posedge clk) begin
        hist <= (hist << 1) | RST_MIN'(rst);
        if (rst) begin
            armed <= 1'b0;
        end else begin
            armed <= armed | (&hist);
        end
    end

    assign live = armed & ~rst;

    generate
        if (RST_MIN > 1) begin : g_pulse_chk
            // A single-clock reset pulse must never start the block (R1).
            assert_short_reset_inert_R1: assert property (@(posedge clk)
                disable iff (rst)
                ($past(rst) && !$past(rst, 2)) |-> !live);
        end
    endgenerate

endmodule

// File: rtl/busseq_fsm.sv
// T-state sequencer: one clock per T-state.
module busseq_fsm
    import busseq_pkg::*;
(
    input  logic      clk,
    input  logic      live,
    input  logic      req_valid,
    input  cyc_kind_e req_kind,
    input  logic      wait_n,
    input  logic      busreq_n,
    output tstate_e   state,
    output cyc_kind_e kind,
    output logic      req_ready,
    output logic      done,
    output logic      rd_latch,
    output logic      refresh_step
);

    tstate_e state_d;
    logic    fin;
    logic    is_io;
    logic    is_fetch;
    logic    is_wr;

    assign is_io    = kind_is_io(kind);
    assign is_fetch = kind_is_fetch(kind);
    assign is_wr    = kind_is_write(kind);

    always_comb begin
        state_d = state;
        fin     = 1'b0;
        unique case (state)
            TS_IDLE: begin
                if (!busreq_n)      state_d = TS_HOLD;
                else if (req_valid) state_d = TS_T1;
            end
            TS_T1: state_d = TS_T2;
            TS_T2: begin
                if (is_io)        state_d = TS_TAUTO;
                else if (!wait_n) state_d = TS_TW;
                else              state_d = TS_T3;
            end
            TS_TAUTO, TS_TW: state_d = wait_n ? TS_T3 : TS_TW;
            TS_T3: begin
                if (is_fetch) state_d = TS_T4;
                else          fin = 1'b1;
            end
            TS_T4:   fin = 1'b1;
            TS_HOLD: state_d = busreq_n ? TS_IDLE : TS_HOLD;
            default: state_d = TS_IDLE;
        endcase
        // Machine-cycle boundary: the only place a bus grant starts.
        if (fin) state_d = busreq_n ? TS_IDLE : TS_HOLD;
    end

    always_ff @(posedge clk) begin
        if (!live) begin
            state <= TS_IDLE;
            kind  <= CK_MEMRD;
            done  <= 1'b0;
        end else begin
            state <= state_d;
            done  <= fin;
            if (state == TS_IDLE && state_d == TS_T1) kind <= req_kind;
        end
    end

    assign req_ready    = live && (state == TS_IDLE) && busreq_n;
    assign rd_latch     = is_fetch ? (state != TS_T3 && state_d == TS_T3)
                                   : (!is_wr && state == TS_T3);
    assign refresh_step = is_fetch && (state == TS_T4);

    assert_accept_to_t1_R2: assert property (@(posedge clk)
        disable iff (!live)
        (req_valid && req_ready) |=> (state == TS_T1));

    assert_hold_at_boundary_R9: assert property (@(posedge clk)
        disable iff (!live)
        (state == TS_HOLD && $past(state) != TS_HOLD) |->
        ($past(state) == TS_IDLE || $past(state) == TS_T3 || $past(state) == TS_T4));

    assert_io_auto_wait_R6: assert property (@(posedge clk)
        disable iff (!live)
        (state == TS_T2 && is_io) |=> (state == TS_TAUTO));

endmodule

// File: rtl/busseq_refresh.sv
// Refresh address counter: low REF_W bits advance, top bit held.
module busseq_refresh #(
    parameter int REF_W = 7
) (
    input  logic         clk,
    input  logic         live,
    input  logic         step,
    output logic [REF_W:0] rcode
);

    logic [REF_W-1:0] ctr;
    logic             top;

    always_ff @(posedge clk) begin
        if (!live) begin
            ctr <= '0;
            top <= 1'b0;
        end else if (step) begin
            ctr <= ctr + 1'b1;
        end
    end

    assign rcode = {top, ctr};

    assert_refresh_advance_R4: assert property (@(posedge clk)
        disable iff (!live)
        step |=> (rcode[REF_W-1:0] != $past(rcode[REF_W-1:0])));

endmodule

// File: rtl/busseq_pins.sv
// Decodes sequencer state into strobes, address/data and enables.
module busseq_pins
    import busseq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int REF_W  = 7
) (
    input  logic              live,
    input  tstate_e           state,
    input  cyc_kind_e         kind,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [DATA_W-1:0] wdata_q,
    input  logic [REF_W:0]    rcode,
    output strobes_t          act,
    output logic [ADDR_W-1:0] addr,
    output logic              addr_oe,
    output logic [DATA_W-1:0] dout,
    output logic              data_oe,
    output logic              ctrl_oe,
    output logic              busack
);

    localparam int PAD_W = ADDR_W - REF_W - 1;

    logic is_io;
    logic is_wr;
    logic is_fetch;

    assign is_io    = kind_is_io(kind);
    assign is_wr    = kind_is_write(kind);
    assign is_fetch = kind_is_fetch(kind);

    always_comb begin
        act = '0;
        unique case (state)
            TS_T1: begin
                act.mreq = !is_io;
                act.rd   = !is_io && !is_wr;
                act.m1   = is_fetch;
            end
            TS_T2, TS_TAUTO, TS_TW: begin
                act.mreq = !is_io;
                act.iorq = is_io;
                act.rd   = !is_wr;
                act.wr   = is_wr;
                act.m1   = is_fetch;
            end
            TS_T3: begin
                if (is_fetch) begin
                    act.mreq = 1'b1;
                    act.rfsh = 1'b1;
                end else begin
                    act.mreq = !is_io;
                    act.iorq = is_io;
                    act.rd   = !is_wr;
                    act.wr   = is_wr;
                end
            end
            TS_T4: begin
                act.mreq = 1'b1;
                act.rfsh = 1'b1;
            end
            default: act = '0;
        endcase
        if (!live) act = '0;
    end

    assign addr    = in_refresh(state, kind) ? {{PAD_W{1'b0}}, rcode} : addr_q;
    assign addr_oe = live && (state != TS_HOLD);
    assign ctrl_oe = live && (state != TS_HOLD);
    assign busack  = live && (state == TS_HOLD);
    assign data_oe = live && is_wr && data_phase(state);
    assign dout    = wdata_q;

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import busseq_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int REF_W   = 7,
    parameter int RST_MIN = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    input  logic              wait_n,
    input  logic              busreq_n,
    output logic              busack_n,
    output logic [ADDR_W-1:0] addr,
    output logic              addr_oe,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              data_oe,
    output logic              mreq_n,
    output logic              iorq_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic              ctrl_oe,
    output logic              m1_n,
    output logic              rfsh_n
);

    logic              live;
    tstate_e           state;
    cyc_kind_e         kind;
    logic              rd_latch;
    logic              refresh_step;
    logic [REF_W:0]    rcode;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    strobes_t          act;
    logic              busack;

    busseq_rstq #(.RST_MIN(RST_MIN)) u_rstq (
        .clk  (clk),
        .rst  (rst),
        .live (live)
    );

    busseq_fsm u_fsm (
        .clk          (clk),
        .live         (live),
        .req_valid    (req_valid),
        .req_kind     (cyc_kind_e'(req_kind)),
        .wait_n       (wait_n),
        .busreq_n     (busreq_n),
        .state        (state),
        .kind         (kind),
        .req_ready    (req_ready),
        .done         (done),
        .rd_latch     (rd_latch),
        .refresh_step (refresh_step)
    );

    busseq_refresh #(.REF_W(REF_W)) u_refresh (
        .clk   (clk),
        .live  (live),
        .step  (refresh_step),
        .rcode (rcode)
    );

    always_ff @(posedge clk) begin
        if (!live) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata   <= '0;
        end else begin
            if (req_valid && req_ready) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (rd_latch) rdata <= din;
        end
    end

    busseq_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REF_W(REF_W)) u_pins (
        .live    (live),
        .state   (state),
        .kind    (kind),
        .addr_q  (addr_q),
        .wdata_q (wdata_q),
        .rcode   (rcode),
        .act     (act),
        .addr    (addr),
        .addr_oe (addr_oe),
        .dout    (dout),
        .data_oe (data_oe),
        .ctrl_oe (ctrl_oe),
        .busack  (busack)
    );

    assign mreq_n   = ~act.mreq;
    assign iorq_n   = ~act.iorq;
    assign rd_n     = ~act.rd;
    assign wr_n     = ~act.wr;
    assign m1_n     = ~act.m1;
    assign rfsh_n   = ~act.rfsh;
    assign busack_n = ~busack;

    always @(posedge clk) begin
        if (rst) begin
            assert_reset_quiet_R1: assert (!addr_oe && !data_oe && !ctrl_oe &&
                mreq_n && iorq_n && rd_n && wr_n && m1_n && rfsh_n &&
                busack_n && !req_ready);
        end
    end

    assert_m1_marks_fetch_R3: assert property (@(posedge clk) disable iff (rst)
        !m1_n |-> (!mreq_n && !rd_n && rfsh_n));

    assert_rfsh_marks_refresh_R4: assert property (@(posedge clk) disable iff (rst)
        !rfsh_n |-> (!mreq_n && rd_n && wr_n && m1_n));

    assert_refresh_addr_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!rfsh_n && $past(!rfsh_n)) |-> (addr == $past(addr)));

    assert_space_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(!mreq_n && !iorq_n));

    assert_dir_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));

    assert_busack_floats_R9: assert property (@(posedge clk) disable iff (rst)
        !busack_n |-> (!addr_oe && !data_oe && !ctrl_oe && !req_ready));

endmodule

// File: tb/test_bus_cycle_seq.sv
module test_bus_cycle_seq;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [2:0]  req_kind;
    logic [15:0] req_addr;
    logic [7:0]  req_wdata;
    logic        req_ready;
    logic        done;
    logic [7:0]  rdata;
    logic        wait_n;
    logic        busreq_n;
    logic        busack_n;
    logic [15:0] addr;
    logic        addr_oe;
    logic [7:0]  din;
    logic [7:0]  dout;
    logic        data_oe;
    logic        mreq_n, iorq_n, rd_n, wr_n, ctrl_oe, m1_n, rfsh_n;

    int checks = 0;
    int fails  = 0;
    int exp_ref = 0;

    always #2 clk = ~clk;

    bus_cycle_seq i_bus_cycle_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .done(done), .rdata(rdata), .wait_n(wait_n), .busreq_n(busreq_n),
        .busack_n(busack_n), .addr(addr), .addr_oe(addr_oe), .din(din),
        .dout(dout), .data_oe(data_oe), .mreq_n(mreq_n), .iorq_n(iorq_n),
        .rd_n(rd_n), .wr_n(wr_n), .ctrl_oe(ctrl_oe), .m1_n(m1_n), .rfsh_n(rfsh_n)
    );

    function automatic logic [7:0] membyte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    // Slow memory: returns contents only while RD is low, filler otherwise.
    always @(negedge clk) din <= (!rd_n) ? membyte(addr) : 8'hEE;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Phase codes: 1 T1, 2 T2, 3 auto wait, 4 wait, 5 T3, 6 T4, 0 none.
    function automatic int phase_of(input int kind, input int nw, input int n);
        if (kind >= 3) begin
            if (n == 0) return 1;
            if (n == 1) return 2;
            if (n == 2) return 3;
            if (n < 3 + nw) return 4;
            if (n == 3 + nw) return 5;
            return 0;
        end
        if (n == 0) return 1;
        if (n == 1) return 2;
        if (n < 2 + nw) return 4;
        if (n == 2 + nw) return 5;
        if (kind == 0 && n == 3 + nw) return 6;
        return 0;
    endfunction

    // {mreq, iorq, rd, wr, m1, rfsh}, active high.
    function automatic logic [5:0] exp_vec(input int kind, input int ph);
        if (ph == 0) return 6'b000000;
        case (kind)
            0: return (ph >= 5) ? 6'b100001 : 6'b101010;
            1: return 6'b101000;
            2: return (ph == 1) ? 6'b100000 : 6'b100100;
            3: return (ph == 1) ? 6'b000000 : 6'b011000;
            default: return (ph == 1) ? 6'b000000 : 6'b010100;
        endcase
    endfunction

    task automatic do_cycle(input int kind, input logic [15:0] a, input logic [7:0] wd,
                            input int nw, input int breq_at, input bit t1_wait);
        int s_first = (kind >= 3) ? 2 : 1;
        int l_exp   = (kind == 0 || kind >= 3) ? 4 + nw : 3 + nw;
        int n = 0;
        int ph;
        bit pin_ok = 1;
        bit ref_ok = 1;
        int bad_got = 0, bad_want = 0;
        logic [5:0] got, want;
        bit doe;
        string tag;
        tag = (kind == 0) ? "R3" : (kind < 3) ? "R5" : "R6";
        if (nw > 0 || t1_wait) tag = {tag, "/R7"};
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_kind  = 3'(kind);
        req_addr  = a;
        req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!done && n < 64) begin
            ph   = phase_of(kind, nw, n);
            got  = ~{mreq_n, iorq_n, rd_n, wr_n, m1_n, rfsh_n};
            want = exp_vec(kind, ph);
            doe  = (kind == 2 || kind == 4) && ph >= 1 && ph <= 5;
            if (got !== want || busack_n !== 1'b1 || data_oe !== doe ||
                (doe && dout !== wd) || addr_oe !== 1'b1 || ctrl_oe !== 1'b1) begin
                if (pin_ok) begin bad_got = int'(got); bad_want = int'(want); end
                pin_ok = 0;
            end
            if (kind == 0 && ph >= 5) begin
                if (addr !== {9'h0, 7'(exp_ref)}) ref_ok = 0;
            end else if (addr !== a) begin
                pin_ok = 0;
            end
            wait_n = !((nw > 0 && n < s_first + nw) || (t1_wait && n == 0));
            if (n == breq_at) busreq_n = 1'b0;
            @(posedge clk);
            @(negedge clk);
            n++;
        end
        wait_n = 1'b1;
        chk(n == l_exp, {tag, " length"}, n, l_exp);
        chk(pin_ok, {tag, " strobes"}, bad_got, bad_want);
        if (kind == 0) begin
            chk(ref_ok, "R4 refresh address", int'(addr), exp_ref);
            exp_ref = (exp_ref + 1) % 128;
        end
        if (kind == 0 || kind == 1 || kind == 3)
            chk(rdata === membyte(a), "R8 read data", int'(rdata), int'(membyte(a)));
        if (breq_at >= 0)
            chk(!busack_n && !addr_oe && !ctrl_oe && !data_oe && !req_ready,
                "R9 grant at boundary", int'(busack_n), 0);
    endtask

    task automatic release_bus();
        @(negedge clk);
        chk(!busack_n && !req_ready, "R9 hold", int'(busack_n), 0);
        busreq_n = 1'b1;
        @(negedge clk);
        chk(busack_n && req_ready && addr_oe, "R9 release", int'(busack_n), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (R2): actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_kind = 3'd0; req_addr = '0;
        req_wdata = '0; wait_n = 1'b1; busreq_n = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(!addr_oe && !data_oe && !ctrl_oe && mreq_n && iorq_n && rd_n && wr_n &&
            m1_n && rfsh_n && busack_n && !req_ready, "R1 reset quiet", int'(addr_oe), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready && addr_oe, "R1 start after full reset", int'(req_ready), 1);

        // Short reset pulse (2 clocks) must leave the block inert.
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        req_valid = 1'b1;
        req_kind  = 3'd1;
        begin
            bit inert = 1;
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                if (req_ready || addr_oe || !mreq_n || !rd_n) inert = 0;
            end
            chk(inert, "R1 short reset inert", int'(req_ready), 0);
        end
        req_valid = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready && addr_oe, "R1 exact-minimum reset", int'(req_ready), 1);
        exp_ref = 0;

        // Sweep every kind against 0..3 waits.
        for (int k = 0; k < 5; k++)
            for (int w = 0; w < 4; w++)
                do_cycle(k, 16'h1234 + 16'(k * 16'h1111) + 16'(w * 16'h0101),
                         8'(8'hA5 ^ (k * 17 + w)), w, -1, 1'b0);

        // Wait low only during T1 must not stretch anything (R7).
        for (int k = 0; k < 5; k++)
            do_cycle(k, 16'h4F00 + 16'(k), 8'h5A, 0, -1, 1'b1);

        // Refresh counter across its wrap (R4).
        for (int i = 0; i < 130; i++)
            do_cycle(0, 16'(i * 257), 8'h00, 0, -1, 1'b0);

        // Bus request during running cycles (R9).
        do_cycle(1, 16'hBEEF, 8'h00, 3, 1, 1'b0);
        release_bus();
        do_cycle(0, 16'h0C0C, 8'h00, 1, 3, 1'b0);
        release_bus();
        do_cycle(4, 16'h00F7, 8'h99, 2, 0, 1'b0);
        release_bus();

        // Bus request while idle, with a request pending during the grant.
        @(negedge clk);
        busreq_n  = 1'b0;
        req_valid = 1'b1;
        req_kind  = 3'd2;
        @(negedge clk);
        begin
            bit quiet = 1;
            for (int i = 0; i < 3; i++) begin
                if (busack_n || addr_oe || !mreq_n || !wr_n || req_ready) quiet = 0;
                @(negedge clk);
            end
            chk(quiet, "R9 idle grant", int'(busack_n), 0);
        end
        req_valid = 1'b0;
        busreq_n  = 1'b1;
        @(negedge clk);
        chk(busack_n && req_ready, "R9 idle release", int'(busack_n), 1);

        do_cycle(3, 16'h0081, 8'h00, 0, -1, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule